// File: doc/BRIEF.md
# Passive Tag Protocol Controller

This block is the central sequencer of a battery-free identification tag. It takes demodulated downlink bits, each marked by a one-cycle valid strobe, and hunts for a frame-start pattern. A 3-bit command follows the pattern. The controller then runs one of five operations. Two of them are identification replies: one for all tags, and one only for tags not yet identified. The other three are an unconditional memory write, an access-checked partial rewrite, and a permanent disable.

For a reply, the controller pulses load strobes to an external transmit buffer and slot scheduler. It waits for the scheduler to report that its slot has come, fires the transmitter and waits for the end of transmission. The next downlink bit is then taken as the reader's verdict. A 1 marks the tag as identified. A 0 bumps a saturating failure counter. The 128-bit register memory is held inside the block and presented in parallel to the transmit buffer. Its upper 64 bits are the identity, followed by a 16-bit check field and 48 spare bits. The tag never verifies the check field; the reader does.

Top module: `tag_proto_ctrl`

## Requirements
- R1: While `rst_n` is low, `ack_flag` is 0, `nak_cnt` is 0, `mem_q` is all zero and `tx_load`, `slot_load` and `tx_start` are 0. `kill_flag` is cleared only while `kill_rst_n` is low; `rst_n` does not change it.
- R2: A frame begins when a 1 is received after at least ten consecutive 0 bits. A 1 after fewer than ten zeros does not start a frame.
- R3: The three bits after frame start are the command, sent MSB first. The codes are Wakeup 000, Request 001, Write 010, Modify 011 and Kill 100. Codes 101, 110 and 111 return the tag to frame hunting with no reply, no memory change and no flag change.
- R4: Wakeup makes a non-killed tag reply whatever its identified flag. `tx_load` and `slot_load` pulse together for exactly one cycle.
- R5: Request makes the tag reply only when `ack_flag` is 0. Otherwise the tag returns to frame hunting silently.
- R6: After the load pulse the tag waits for `slot_zero`. It then pulses `tx_start` for one cycle and waits for `tx_done`. After that it takes the next received bit as the reader's response.
- R7: A response bit of 1 sets `ack_flag`, which stays set until `rst_n`. A response bit of 0 increments `nak_cnt` by one, saturating at 15.
- R8: Write takes 128 bits. The first received bit is stored into `mem_q[127]` and later bits go to successively lower positions. The check field `mem_q[63:48]` is stored as received, with no verification.
- R9: Modify compares 64 received bits one by one against `mem_q[127:64]`, MSB first. On a full match the next 64 bits are written into `mem_q[63:0]`, MSB first. At the first differing bit the operation is abandoned, memory is unchanged and later bits are treated as frame-hunting input.
- R10: Kill compares 64 received bits against `mem_q[127:64]` in the same way. A full match sets `kill_flag`. A mismatch leaves it clear.
- R11: A tag with `kill_flag` set starts no frame. It never pulses `tx_load` or `tx_start` and never writes memory until `kill_rst_n` is pulsed low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Baseband clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| kill_rst_n | input | 1 | Asynchronous active-low test reset of the kill flag only |
| rx_bit | input | 1 | Demodulated downlink bit |
| rx_valid | input | 1 | One-cycle strobe marking `rx_bit` as a new bit |
| slot_zero | input | 1 | Slot scheduler reports the tag's slot has arrived |
| tx_done | input | 1 | Transmitter reports the reply has been sent |
| tx_load | output | 1 | Load pulse to the transmit buffer |
| slot_load | output | 1 | Load pulse to the slot scheduler |
| tx_start | output | 1 | Start pulse to the transmitter |
| tx_data | output | 128 | Memory contents presented to the transmit buffer |
| ack_flag | output | 1 | Tag has been identified |
| nak_cnt | output | 4 | Saturating count of failed transmissions |
| kill_flag | output | 1 | Tag is permanently disabled |

## Verification
On every cycle the checker checks several invariants. A killed tag never loads, starts or writes. Load and start are single-cycle pulses. Memory changes only on a write enable. The identified flag is sticky. The failure counter only ever steps up by one and holds once it reaches 15. The bench scenarios are needed for the behaviour that depends on the bit stream. This covers the frame-start threshold, decoding of each command code, and the Request filter. It also covers bit order on write, abandoning a mismatch at the first differing identity bit, and the kill flag surviving a power-on reset while yielding to its own reset.

// File: rtl/tagp_pkg.sv
package tagp_pkg;

  localparam int CMD_W = 3;

  typedef enum logic [CMD_W-1:0] {
    CMD_WAKEUP  = 3'b000,
    CMD_REQUEST = 3'b001,
    CMD_WRITE   = 3'b010,
    CMD_MODIFY  = 3'b011,
    CMD_KILL    = 3'b100
  } cmd_e;

  typedef enum logic [3:0] {
    ST_HALT   = 4'd0,
    ST_CMD    = 4'd1,
    ST_WRITE  = 4'd2,
    ST_ACCESS = 4'd3,
    ST_MODWR  = 4'd4,
    ST_LOAD   = 4'd5,
    ST_SLOT   = 4'd6,
    ST_FIRE   = 4'd7,
    ST_TXWAIT = 4'd8,
    ST_RSP    = 4'd9
  } state_e;

endpackage

// File: rtl/tagp_sof_det.sv
module tagp_sof_det #(
  parameter int ZEROS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic bit_in,
  input  logic bit_vld,
  output logic sof_hit
);
  localparam int ZW = $clog2(ZEROS + 1);

  logic [ZW-1:0] zcnt_q, zcnt_d;
  logic          zcnt_en;

  // a run of zeros of length ZEROS or more, then a one
  assign sof_hit = en && bit_vld && bit_in && (zcnt_q == ZW'(ZEROS));

  always_comb begin
    zcnt_en = 1'b0;
    zcnt_d  = zcnt_q;
    if (!en) begin
      zcnt_en = (zcnt_q != '0);
      zcnt_d  = '0;
    end else if (bit_vld) begin
      zcnt_en = 1'b1;
      if (bit_in)
        zcnt_d = '0;
      else if (zcnt_q != ZW'(ZEROS))
        zcnt_d = zcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      zcnt_q <= '0;
    else if (zcnt_en)
      zcnt_q <= zcnt_d;
  end

endmodule

// File: rtl/tagp_regmem.sv
module tagp_regmem #(
  parameter int W = 128
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [$clog2(W)-1:0] addr,
  input  logic                 wbit,
  output logic [W-1:0]         q
);
  logic [W-1:0] mem_q;

  for (genvar g = 0; g < W; g++) begin : g_cell
    logic cell_en;
    assign cell_en = we && (addr == g[$clog2(W)-1:0]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mem_q[g] <= 1'b0;
      else if (cell_en)
        mem_q[g] <= wbit;
    end
  end

  assign q = mem_q;

endmodule

// File: rtl/tagp_flags.sv
module tagp_flags #(
  parameter int NAK_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kill_rst_n,
  input  logic             ack_set,
  input  logic             nak_inc,
  input  logic             kill_set,
  output logic             ack_flag,
  output logic [NAK_W-1:0] nak_cnt,
  output logic             kill_flag
);
  logic             ack_q;
  logic [NAK_W-1:0] nak_q, nak_d;
  logic             nak_en;
  logic             kill_q;

  assign nak_en = nak_inc && (nak_q != {NAK_W{1'b1}});
  assign nak_d  = nak_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ack_q <= 1'b0;
    else if (ack_set)
      ack_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      nak_q <= '0;
    else if (nak_en)
      nak_q <= nak_d;
  end

  // kill state lives in its own reset domain
  always_ff @(posedge clk or negedge kill_rst_n) begin
    if (!kill_rst_n)
      kill_q <= 1'b0;
    else if (kill_set)
      kill_q <= 1'b1;
  end

  assign ack_flag  = ack_q;
  assign nak_cnt   = nak_q;
  assign kill_flag = kill_q;

endmodule

// File: rtl/tag_proto_ctrl.sv
module tag_proto_ctrl #(
  parameter int MEM_W     = 128,
  parameter int ID_W      = 64,
  parameter int NAK_W     = 4,
  parameter int SOF_ZEROS = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kill_rst_n,
  input  logic             rx_bit,
  input  logic             rx_valid,
  input  logic             slot_zero,
  input  logic             tx_done,
  output logic             tx_load,
  output logic             slot_load,
  output logic             tx_start,
  output logic [MEM_W-1:0] tx_data,
  output logic             ack_flag,
  output logic [NAK_W-1:0] nak_cnt,
  output logic             kill_flag
);
  import tagp_pkg::*;

  localparam int AW = $clog2(MEM_W);
  localparam logic [AW-1:0] LAST_BIT = AW'(MEM_W - 1);
  localparam logic [AW-1:0] LAST_ID  = AW'(ID_W - 1);
  localparam logic [AW-1:0] LAST_CMD = AW'(CMD_W - 1);

  state_e           st_q, st_d;
  logic [AW-1:0]    cnt_q, cnt_d;
  logic [CMD_W-1:0] cmd_q, cmd_d, cmd_next;
  logic             st_en, cnt_en, cmd_en;

  logic             sof_hit;
  logic             mem_we;
  logic [AW-1:0]    mem_idx;
  logic [MEM_W-1:0] mem_q;
  logic             ack_set, nak_inc, kill_set;

  tagp_sof_det #(.ZEROS(SOF_ZEROS)) u_sof (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (st_q == ST_HALT),
    .bit_in  (rx_bit),
    .bit_vld (rx_valid),
    .sof_hit (sof_hit)
  );

  tagp_regmem #(.W(MEM_W)) u_mem (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (mem_we),
    .addr  (mem_idx),
    .wbit  (rx_bit),
    .q     (mem_q)
  );

  tagp_flags #(.NAK_W(NAK_W)) u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .kill_rst_n (kill_rst_n),
    .ack_set    (ack_set),
    .nak_inc    (nak_inc),
    .kill_set   (kill_set),
    .ack_flag   (ack_flag),
    .nak_cnt    (nak_cnt),
    .kill_flag  (kill_flag)
  );

  // received data bits fill memory from the top position down
  assign mem_idx  = LAST_BIT - cnt_q;
  assign cmd_next = {cmd_q[CMD_W-2:0], rx_bit};

  function automatic state_e decode(input logic [CMD_W-1:0] code, input logic acked);
    case (code)
      CMD_WAKEUP:  decode = ST_LOAD;
      CMD_REQUEST: decode = acked ? ST_HALT : ST_LOAD;
      CMD_WRITE:   decode = ST_WRITE;
      CMD_MODIFY:  decode = ST_ACCESS;
      CMD_KILL:    decode = ST_ACCESS;
      default:     decode = ST_HALT;
    endcase
  endfunction

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    cmd_d    = cmd_q;
    mem_we   = 1'b0;
    ack_set  = 1'b0;
    nak_inc  = 1'b0;
    kill_set = 1'b0;
    case (st_q)
      ST_HALT: begin
        cnt_d = '0;
        if (sof_hit && !kill_flag)
          st_d = ST_CMD;
      end
      ST_CMD: begin
        if (rx_valid) begin
          cmd_d = cmd_next;
          if (cnt_q == LAST_CMD) begin
            cnt_d = '0;
            st_d  = decode(cmd_next, ack_flag);
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      ST_WRITE: begin
        if (rx_valid) begin
          mem_we = 1'b1;
          cnt_d  = cnt_q + 1'b1;
          if (cnt_q == LAST_BIT)
            st_d = ST_HALT;
        end
      end
      ST_ACCESS: begin
        if (rx_valid) begin
          cnt_d = cnt_q + 1'b1;
          if (rx_bit != mem_q[mem_idx]) begin
            st_d = ST_HALT;
          end else if (cnt_q == LAST_ID) begin
            if (cmd_q == CMD_KILL) begin
              kill_set = 1'b1;
              st_d     = ST_HALT;
            end else begin
              st_d = ST_MODWR;
            end
          end
        end
      end
      ST_MODWR: begin
        if (rx_valid) begin
          mem_we = 1'b1;
          cnt_d  = cnt_q + 1'b1;
          if (cnt_q == LAST_BIT)
            st_d = ST_HALT;
        end
      end
      ST_LOAD:   st_d = ST_SLOT;
      ST_SLOT:   if (slot_zero) st_d = ST_FIRE;
      ST_FIRE:   st_d = ST_TXWAIT;
      ST_TXWAIT: if (tx_done) st_d = ST_RSP;
      ST_RSP: begin
        if (rx_valid) begin
          ack_set = rx_bit;
          nak_inc = !rx_bit;
          st_d    = ST_HALT;
        end
      end
      default:   st_d = ST_HALT;
    endcase
  end

  assign st_en  = (st_d != st_q);
  assign cnt_en = (cnt_d != cnt_q);
  assign cmd_en = (st_q == ST_CMD) && rx_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      st_q <= ST_HALT;
    else if (st_en)
      st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_en)
      cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cmd_q <= '0;
    else if (cmd_en)
      cmd_q <= cmd_d;
  end

  assign tx_load   = (st_q == ST_LOAD);
  assign slot_load = (st_q == ST_LOAD);
  assign tx_start  = (st_q == ST_FIRE);
  assign tx_data   = mem_q;

endmodule

// File: rtl/tagp_checker.sv
module tagp_checker #(
  parameter int MEM_W = 128,
  parameter int NAK_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             kill_rst_n,
  input logic             tx_load,
  input logic             slot_load,
  input logic             tx_start,
  input logic [MEM_W-1:0] tx_data,
  input logic             ack_flag,
  input logic [NAK_W-1:0] nak_cnt,
  input logic             kill_flag,
  input logic             mem_we
);

  AST_KILL_SILENT: assert property (@(posedge clk) disable iff (!rst_n || !kill_rst_n)
    kill_flag |-> !tx_load && !tx_start && !mem_we) else $error("kill silent"); // R11

  AST_LOAD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> !tx_load && !slot_load && !tx_start) else $error("load pulse"); // R4

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> !tx_start && !tx_load) else $error("start pulse"); // R6

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we |=> $stable(tx_data)) else $error("mem hold"); // R8

  AST_ACK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ack_flag |=> ack_flag) else $error("ack sticky"); // R7

  AST_NAK_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    (nak_cnt == {NAK_W{1'b1}}) |=> (nak_cnt == {NAK_W{1'b1}})) else $error("nak sat"); // R7

  AST_NAK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(nak_cnt) |-> (nak_cnt == $past(nak_cnt) + 1'b1)) else $error("nak step"); // R7

endmodule

bind tag_proto_ctrl tagp_checker #(.MEM_W(MEM_W), .NAK_W(NAK_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .kill_rst_n (kill_rst_n),
  .tx_load    (tx_load),
  .slot_load  (slot_load),
  .tx_start   (tx_start),
  .tx_data    (tx_data),
  .ack_flag   (ack_flag),
  .nak_cnt    (nak_cnt),
  .kill_flag  (kill_flag),
  .mem_we     (mem_we)
);

// File: tb/test_tag_proto_ctrl.sv
module test_tag_proto_ctrl;
  localparam int CLK_P = 10;
  localparam int EV_LOAD  = 1;
  localparam int EV_START = 2;

  logic         clk = 1'b0;
  logic         rst_n, kill_rst_n;
  logic         rx_bit, rx_valid, slot_zero, tx_done;
  logic         tx_load, slot_load, tx_start;
  logic [127:0] tx_data;
  logic         ack_flag, kill_flag;
  logic [3:0]   nak_cnt;

  int n_cmp = 0;
  int n_err = 0;
  int exp_q[$];

  localparam logic [127:0] D1 = 128'h5A5A_3C3C_9696_E1E1_7B7B_4242_C6C6_1F1F;
  localparam logic [127:0] D2 = 128'hB7B7_6969_A5A5_1E1E_CACA_3535_9191_7777;
  localparam logic [63:0]  NEW_LO = 64'h8181_7E7E_2424_DBDB;

  always #(CLK_P/2) clk = ~clk;

  tag_proto_ctrl i_tag_proto_ctrl (
    .clk(clk), .rst_n(rst_n), .kill_rst_n(kill_rst_n),
    .rx_bit(rx_bit), .rx_valid(rx_valid), .slot_zero(slot_zero), .tx_done(tx_done),
    .tx_load(tx_load), .slot_load(slot_load), .tx_start(tx_start), .tx_data(tx_data),
    .ack_flag(ack_flag), .nak_cnt(nak_cnt), .kill_flag(kill_flag)
  );

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // monitor: pops expected transmit events as they appear
  always @(negedge clk) begin
    if (rst_n && (tx_load || tx_start)) begin
      int ev;
      int want;
      ev = tx_load ? EV_LOAD : EV_START;
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_err++;
        $display("FAIL R4/R6/R11 unexpected event act=%0d exp=none", ev);
      end else begin
        want = exp_q.pop_front();
        if (want != ev || (tx_load !== slot_load)) begin
          n_err++;
          $display("FAIL R4/R6 event act=%0d/%0b exp=%0d/%0b", ev, slot_load, want, tx_load);
        end
      end
    end
  end

  task automatic send_bit(logic b);
    @(negedge clk);
    rx_bit = b; rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic send_sof();
    for (int i = 0; i < 10; i++) send_bit(1'b0);
    send_bit(1'b1);
  endtask

  task automatic send_cmd(logic [2:0] c);
    for (int i = 2; i >= 0; i--) send_bit(c[i]);
  endtask

  task automatic send_64(logic [63:0] v);
    for (int i = 63; i >= 0; i--) send_bit(v[i]);
  endtask

  // driver side of a reply slot: pushes expected events, answers the handshake
  task automatic reply_cycle(string req, logic expect_reply, logic rsp);
    if (expect_reply) begin
      exp_q.push_back(EV_LOAD);
      exp_q.push_back(EV_START);
    end
    repeat (4) @(negedge clk);
    slot_zero = 1'b1; @(negedge clk); slot_zero = 1'b0;
    repeat (2) @(negedge clk);
    tx_done = 1'b1; @(negedge clk); tx_done = 1'b0;
    repeat (2) @(negedge clk);
    if (expect_reply) send_bit(rsp);
    repeat (2) @(negedge clk);
    check(req, 128'(exp_q.size()), 128'd0);
  endtask

  task automatic frame_cmd(logic [2:0] c);
    send_sof();
    send_cmd(c);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0; kill_rst_n = 1'b0;
    rx_bit = 1'b0; rx_valid = 1'b0; slot_zero = 1'b0; tx_done = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 ack", 128'(ack_flag), 0);
    check("R1 nak", 128'(nak_cnt), 0);
    check("R1 kill", 128'(kill_flag), 0);
    check("R1 mem", tx_data, 0);
    check("R1 strobes", 128'({tx_load, slot_load, tx_start}), 0);
    rst_n = 1'b1; kill_rst_n = 1'b1;
    @(negedge clk);

    // R4 R6 R7 wakeup, NAK response
    frame_cmd(3'b000);
    reply_cycle("R4 wakeup reply", 1'b1, 1'b0);
    check("R7 nak after 0", 128'(nak_cnt), 1);
    check("R7 ack still 0", 128'(ack_flag), 0);

    // R2 only nine zeros: no frame
    for (int i = 0; i < 9; i++) send_bit(1'b0);
    send_bit(1'b1);
    send_cmd(3'b000);
    reply_cycle("R2 short sof silent", 1'b0, 1'b0);

    // R3 undefined code
    frame_cmd(3'b101);
    reply_cycle("R3 bad code silent", 1'b0, 1'b0);
    check("R3 nak unchanged", 128'(nak_cnt), 1);
    check("R3 mem unchanged", tx_data, 0);

    // R8 write, check field stored unverified
    frame_cmd(3'b010);
    send_64(D1[127:64]);
    send_64(D1[63:0]);
    repeat (2) @(negedge clk);
    check("R8 write order", tx_data, D1);

    // R5 request with ack clear, then ACK
    frame_cmd(3'b001);
    reply_cycle("R5 request replies", 1'b1, 1'b1);
    check("R7 ack set", 128'(ack_flag), 1);
    frame_cmd(3'b001);
    reply_cycle("R5 request skips acked", 1'b0, 1'b0);

    // R4 wakeup still replies when acked
    frame_cmd(3'b000);
    reply_cycle("R4 wakeup acked", 1'b1, 1'b0);
    check("R7 nak 2", 128'(nak_cnt), 2);
    check("R7 ack sticky", 128'(ack_flag), 1);

    // R7 saturation
    for (int i = 0; i < 13; i++) begin
      frame_cmd(3'b000);
      reply_cycle("R7 nak run", 1'b1, 1'b0);
    end
    check("R7 nak 15", 128'(nak_cnt), 15);
    frame_cmd(3'b000);
    reply_cycle("R7 nak more", 1'b1, 1'b0);
    check("R7 nak saturates", 128'(nak_cnt), 15);

    // R9 modify with wrong identity
    frame_cmd(3'b011);
    send_64(D1[127:64] ^ 64'h0400_0000_0000_0000);
    send_64(NEW_LO);
    repeat (2) @(negedge clk);
    check("R9 mismatch no write", tx_data, D1);
    frame_cmd(3'b000);
    reply_cycle("R9 back in halt", 1'b1, 1'b1);

    // R9 modify with matching identity
    frame_cmd(3'b011);
    send_64(D1[127:64]);
    send_64(NEW_LO);
    repeat (2) @(negedge clk);
    check("R9 modify low half", tx_data, {D1[127:64], NEW_LO});

    // R10 kill wrong then right
    frame_cmd(3'b100);
    send_64(D1[127:64] ^ 64'h0000_0000_0000_0001);
    repeat (2) @(negedge clk);
    check("R10 wrong id no kill", 128'(kill_flag), 0);
    frame_cmd(3'b100);
    send_64(D1[127:64]);
    repeat (2) @(negedge clk);
    check("R10 kill set", 128'(kill_flag), 1);

    // R11 killed tag silent and write-protected
    frame_cmd(3'b000);
    reply_cycle("R11 killed no reply", 1'b0, 1'b0);
    frame_cmd(3'b010);
    send_64(D2[127:64]);
    send_64(D2[63:0]);
    repeat (2) @(negedge clk);
    check("R11 killed no write", tx_data, {D1[127:64], NEW_LO});

    // R1 R11 power reset keeps kill
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1 ack on reset", 128'(ack_flag), 0);
    check("R1 nak on reset", 128'(nak_cnt), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 kill survives rst_n", 128'(kill_flag), 1);

    // R11 test reset clears kill
    kill_rst_n = 1'b0; @(negedge clk); kill_rst_n = 1'b1;
    @(negedge clk);
    check("R11 kill cleared", 128'(kill_flag), 0);
    frame_cmd(3'b000);
    reply_cycle("R11 replies again", 1'b1, 1'b1);
    check("R7 ack after revive", 128'(ack_flag), 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end

endmodule